// File: doc/BRIEF.md
# Dual-Channel Power-Good Delay Monitor

This block produces one power-good indication for a pair of switching converter channels. Each channel supplies an in-window flag from its own feedback comparators, plus an enable. The block decides which channels take part in the decision. A channel that is switched off is left out of it. When no channel is enabled the indication is never good.

The result drives an open-drain pin. The output is therefore a pull-down request: `1` holds the pin low, and `0` lets an external resistor pull it high. Release is slow and programmable. The good condition must persist for 1, 50, 150 or 200 ms, chosen by a 2-bit select. A fault pulls the pin low after a short fixed filter instead. The millisecond timebase is divided down from the system clock inside the block.

Top module: `pwrgood_delay_mon`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pg_pull_low` is 1.
- R2: With both channels enabled, the good condition holds only when both `ch_in_win` bits are 1.
- R3: With exactly one channel enabled, the good condition follows that channel's `ch_in_win` bit, and the other channel's bit has no effect on `pg_pull_low`.
- R4: With both enables 0, the output is never released. A released output is pulled low after the fall filter.
- R5: `dly_sel` selects the release delay: 2'b00 gives 1 ms, 2'b01 gives 50 ms, 2'b10 gives 150 ms and 2'b11 gives 200 ms. One ms is `CLKS_PER_MS` clocks. `pg_pull_low` falls after exactly delay_ms × `CLKS_PER_MS` consecutive qualifying clock edges. `dly_sel` is held stable during a count.
- R6: Any cycle in which the good condition is false while the output is low restarts the release count from zero.
- R7: A released output returns to 1 after `FALL_CYCLES` consecutive edges with the condition false. A shorter bad stretch leaves it released.
- R8: An edge at which `ch_en` differs from its value on the previous edge never counts toward either delay. It restarts the running count.
- R9: While released and the condition stays good, `pg_pull_low` remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel enable, bit i for channel i |
| ch_in_win | input | NUM_CH | Per-channel in-window flag from the comparators |
| dly_sel | input | 2 | Release delay select (see R5) |
| pg_pull_low | output | 1 | 1 = pull the open-drain pin low, 0 = release |

## Verification
On every cycle, the bound checker enforces the following:
- the reset state;
- that a release is preceded by a good cycle and a pull-down by a bad one;
- that nothing releases with no channel enabled or on an enable change;
- that a released output holds while the condition is good.

The exact release delay for each select code, the restart after a dropout, the filtering of short faults and the indifference to a disabled channel's flag all depend on counts of cycles. Only the bench's scenarios show these, against its cycle-by-cycle reference model.

// File: rtl/pg_pkg.sv
// Shared types for the power-good delay monitor.
// Assumes: a two-state output decision, low (pull-down) or released.
package pg_pkg;

    typedef enum logic {
        PG_HOLD_LOW = 1'b0,
        PG_RELEASED = 1'b1
    } pg_state_e;

    typedef struct packed {
        logic good;      // qualified combined window condition
        logic en_moved;  // enable pattern differs from previous cycle
    } pg_qual_t;

endpackage

// File: rtl/pg_qualify.sv
// Channel qualification: folds per-channel window flags into one good
// condition, counting only enabled channels, and flags an enable change.
// Assumes: flags are already synchronous to clk.
module pg_qualify
    import pg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_in_win,
    output pg_qual_t          qual
);

    logic [NUM_CH-1:0] ch_ok;
    logic [NUM_CH-1:0] en_q;

    // A disabled channel never vetoes; an enabled one needs its window.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_ok[i] = ~ch_en[i] | ch_in_win[i];
    end

    // Remember last enable pattern to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= ch_en;
        end
    end

    // Combined condition: at least one participant and no veto.
    always_comb begin
        qual.good     = (|ch_en) & (&ch_ok);
        qual.en_moved = (ch_en != en_q);
    end

endmodule

// File: rtl/pg_ms_tick.sv
// Millisecond prescaler: while run is high, emits a one-cycle tick every
// CLKS_PER_MS clocks; dropping run clears the phase so timing restarts.
// Assumes: CLKS_PER_MS >= 2.
module pg_ms_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int PRE_W = $clog2(CLKS_PER_MS);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

    logic [PRE_W-1:0] pre;

    assign tick = run && (pre == PRE_LAST);

    // Free-run the phase while counting, otherwise hold it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre <= '0;
        end else if (pre == PRE_LAST) begin
            pre <= '0;
        end else begin
            pre <= pre + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pg_delay.sv
// Asymmetric delay state machine: slow programmable release counted in
// millisecond ticks, fast fixed fall filter counted in clocks.
// Assumes: DLY_MS3 is the largest delay, all delays >= 1, FALL_CYCLES >= 1.
module pg_delay
    import pg_pkg::*;
#(
    parameter int DLY_MS0     = 1,
    parameter int DLY_MS1     = 50,
    parameter int DLY_MS2     = 150,
    parameter int DLY_MS3     = 200,
    parameter int FALL_CYCLES = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pg_qual_t   qual,
    input  logic [1:0] dly_sel,
    input  logic       ms_tick,
    output logic       rise_run,
    output logic       pull_low
);

    localparam int MS_W   = $clog2(DLY_MS3 + 1);
    localparam int FALL_W = $clog2(FALL_CYCLES + 1);
    localparam logic [FALL_W-1:0] FALL_LAST = FALL_W'(FALL_CYCLES - 1);

    pg_state_e        state;
    logic [MS_W-1:0]  ms_cnt;
    logic [MS_W-1:0]  tgt_ms;
    logic [FALL_W-1:0] fall_cnt;
    logic             fall_run;

    // Map the select code onto its delay in milliseconds.
    always_comb begin
        case (dly_sel)
            2'b00:   tgt_ms = MS_W'(DLY_MS0);
            2'b01:   tgt_ms = MS_W'(DLY_MS1);
            2'b10:   tgt_ms = MS_W'(DLY_MS2);
            default: tgt_ms = MS_W'(DLY_MS3);
        endcase
    end

    // An edge counts only if the condition suits the state and enables held.
    always_comb begin
        rise_run = (state == PG_HOLD_LOW) && qual.good  && !qual.en_moved;
        fall_run = (state == PG_RELEASED) && !qual.good && !qual.en_moved;
    end

    // State, release counter and fall filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PG_HOLD_LOW;
            ms_cnt   <= '0;
            fall_cnt <= '0;
        end else begin
            case (state)
                PG_HOLD_LOW: begin
                    fall_cnt <= '0;
                    if (!rise_run) begin
                        ms_cnt <= '0;
                    end else if (ms_tick) begin
                        if ((ms_cnt + MS_W'(1)) >= tgt_ms) begin
                            state  <= PG_RELEASED;
                            ms_cnt <= '0;
                        end else begin
                            ms_cnt <= ms_cnt + MS_W'(1);
                        end
                    end
                end
                default: begin
                    ms_cnt <= '0;
                    if (!fall_run) begin
                        fall_cnt <= '0;
                    end else if (fall_cnt == FALL_LAST) begin
                        state    <= PG_HOLD_LOW;
                        fall_cnt <= '0;
                    end else begin
                        fall_cnt <= fall_cnt + FALL_W'(1);
                    end
                end
            endcase
        end
    end

    assign pull_low = (state == PG_HOLD_LOW);

endmodule

// File: rtl/pwrgood_delay_mon.sv
// Top: combined power-good pull-down request for NUM_CH converter channels.
// Qualifies channels by enable, then releases after a programmable
// millisecond delay and pulls low after a short fixed clock filter.
// Assumes: window flags synchronous to clk; CLKS_PER_MS >= 2.
module pwrgood_delay_mon
    import pg_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CLKS_PER_MS = 50000,
    parameter int DLY_MS0     = 1,
    parameter int DLY_MS1     = 50,
    parameter int DLY_MS2     = 150,
    parameter int DLY_MS3     = 200,
    parameter int FALL_CYCLES = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_in_win,
    input  logic [1:0]        dly_sel,
    output logic              pg_pull_low
);

    pg_qual_t qual;
    logic     rise_run;
    logic     ms_tick;

    pg_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .ch_in_win (ch_in_win),
        .qual      (qual)
    );

    pg_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rise_run),
        .tick  (ms_tick)
    );

    pg_delay #(
        .DLY_MS0     (DLY_MS0),
        .DLY_MS1     (DLY_MS1),
        .DLY_MS2     (DLY_MS2),
        .DLY_MS3     (DLY_MS3),
        .FALL_CYCLES (FALL_CYCLES)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .dly_sel  (dly_sel),
        .ms_tick  (ms_tick),
        .rise_run (rise_run),
        .pull_low (pg_pull_low)
    );

endmodule

// File: rtl/pwrgood_delay_mon_chk.sv
// Port-level checker for pwrgood_delay_mon, attached by bind below.
// Assumes: synchronous active-low reset.
module pwrgood_delay_mon_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_in_win,
    input logic              pg_pull_low
);

    logic good;
    assign good = (ch_en != '0) && ((ch_en & ~ch_in_win) == '0);

    // R1: first cycle out of reset still pulls low
    a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pg_pull_low);

    // R2/R3: a release is preceded by a good qualified condition
    a_r2_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_pull_low) |-> $past(good));

    // R7: a pull-down is preceded by a bad condition
    a_r7_fall_needs_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_pull_low) |-> !$past(good));

    // R4: no enabled channel never releases
    a_r4_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_en == '0) && pg_pull_low) |=> pg_pull_low);

    // R8: an enable change cannot complete a release
    a_r8_en_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_en != $past(ch_en)) && pg_pull_low) |=> pg_pull_low);

    // R9: released output holds while the condition is good
    a_r9_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_pull_low && good) |=> !pg_pull_low);

endmodule

bind pwrgood_delay_mon pwrgood_delay_mon_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (ch_en),
    .ch_in_win   (ch_in_win),
    .pg_pull_low (pg_pull_low)
);

// File: tb/pwrgood_delay_mon_tb.sv
module pwrgood_delay_mon_tb;

    localparam int CPM  = 4;
    localparam int FALL = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] en = 2'b00;
    logic [1:0] win = 2'b00;
    logic [1:0] sel = 2'b00;
    logic       pl;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // reference model state
    int       m_low = 1;
    int       m_cnt = 0;
    logic [1:0] m_en_prev = 2'b00;

    always #10 clk = ~clk;

    pwrgood_delay_mon #(
        .NUM_CH(2), .CLKS_PER_MS(CPM), .FALL_CYCLES(FALL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_en(en), .ch_in_win(win),
        .dly_sel(sel), .pg_pull_low(pl)
    );

    function automatic int ms_of(logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 50;
            2'b10:   return 150;
            default: return 200;
        endcase
    endfunction

    function automatic bit cond_of(logic [1:0] e, logic [1:0] w);
        case (e)
            2'b01:   return w[0];
            2'b10:   return w[1];
            2'b11:   return w[0] && w[1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(logic act, logic exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: pg_pull_low=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference, evaluated per rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_low = 1; m_cnt = 0; m_en_prev = 2'b00;
        end else begin
            bit g, moved;
            g = cond_of(en, win);
            moved = (en != m_en_prev);
            m_en_prev = en;
            if (m_low == 1) begin
                if (g && !moved) begin
                    m_cnt++;
                    if (m_cnt >= ms_of(sel) * CPM) begin m_low = 0; m_cnt = 0; end
                end else m_cnt = 0;
            end else begin
                if (!g && !moved) begin
                    m_cnt++;
                    if (m_cnt >= FALL) begin m_low = 1; m_cnt = 0; end
                end else m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) chk(pl, m_low[0], cur_req);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        chk(pl, 1'b1, "R1 in reset");
        rst_n = 1'b1;
        step(1);
        chk(pl, 1'b1, "R1 after reset");

        // R2/R5: both enabled, 1 ms code
        cur_req = "R2";
        en = 2'b11; step(1);
        win = 2'b11; sel = 2'b00;
        step(CPM - 1); chk(pl, 1'b1, "R5 one before 1ms");
        step(1);       chk(pl, 1'b0, "R5 released at 1ms");
        cur_req = "R9";
        step(20);      chk(pl, 1'b0, "R9 holds while good");

        // R7: short glitch is filtered
        cur_req = "R7";
        win = 2'b01; step(FALL - 2); chk(pl, 1'b0, "R7 short bad ignored");
        win = 2'b11; step(2);        chk(pl, 1'b0, "R7 still released");

        // R2: one channel out of window pulls low after filter
        cur_req = "R2";
        win = 2'b10; step(FALL - 1); chk(pl, 1'b0, "R7 before filter end");
        step(1);                     chk(pl, 1'b1, "R2 one bad pulls low");

        // R6: dropout restarts release count (50 ms code)
        cur_req = "R6";
        win = 2'b11; sel = 2'b01; step(100);
        win = 2'b10; step(1);
        win = 2'b11; step(50 * CPM - 1); chk(pl, 1'b1, "R6 restarted count");
        step(1);                        chk(pl, 1'b0, "R6 release after full 50ms");

        // R3: only channel 0 enabled, channel 1 flag ignored
        cur_req = "R3";
        en = 2'b01; win = 2'b01; step(30); chk(pl, 1'b0, "R3 ch1 bad ignored");
        win = 2'b00; step(FALL);          chk(pl, 1'b1, "R3 ch0 bad pulls low");
        win = 2'b10; step(300);           chk(pl, 1'b1, "R3 ch1 good ignored");
        en = 2'b10; sel = 2'b00; step(1);
        step(CPM - 1); chk(pl, 1'b1, "R3 ch1 counting");
        step(1);       chk(pl, 1'b0, "R3 ch1 alone releases");

        // R4/R8: disable all while good
        cur_req = "R4";
        en = 2'b00; win = 2'b11;
        step(FALL); chk(pl, 1'b0, "R8 change edge not counted");
        step(1);    chk(pl, 1'b1, "R4 none enabled pulls low");
        step(1000); chk(pl, 1'b1, "R4 stays low");

        // R8: enable change delays and restarts release
        cur_req = "R8";
        en = 2'b11; sel = 2'b00;
        step(CPM); chk(pl, 1'b1, "R8 change edge delays release");
        step(1);   chk(pl, 1'b0, "R8 release one later");
        win = 2'b00; step(FALL); chk(pl, 1'b1, "R7 fall");
        win = 2'b11; step(2);
        en = 2'b01; step(CPM); chk(pl, 1'b1, "R8 count restarted");
        step(1);               chk(pl, 1'b0, "R8 release after restart");

        // R5: 150 ms and 200 ms codes
        cur_req = "R5";
        win = 2'b00; step(FALL); chk(pl, 1'b1, "R7 fall");
        sel = 2'b10; win = 2'b01;
        step(150 * CPM - 1); chk(pl, 1'b1, "R5 before 150ms");
        step(1);             chk(pl, 1'b0, "R5 at 150ms");
        win = 2'b00; step(FALL); chk(pl, 1'b1, "R7 fall");
        sel = 2'b11; win = 2'b01;
        step(200 * CPM - 1); chk(pl, 1'b1, "R5 before 200ms");
        step(1);             chk(pl, 1'b0, "R5 at 200ms");

        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule